// File: doc/BRIEF.md
# Round-to-Odd Single-Precision Result Packer

This block turns an unrounded single-precision result into a packed 32-bit IEEE-format word. The upstream datapath presents a sign, an unbiased two's-complement exponent, a normalized mantissa whose most significant bit is the hidden one, a few guard bits below the kept fraction, a sticky bit, and three class tags: NaN, infinity and zero.

The block rounds with round-to-odd. Discarded bits are never rounded up. If any of them is nonzero, the least significant fraction bit is forced to one. Because the fraction is never incremented, no renormalization step follows. Results too large for the format become infinity with the result's sign. Results in the denormal range become a zero with the result's sign. Every NaN becomes the single default NaN, whatever sign or payload arrived.

The block keeps no exception flags and raises no traps. The logic is combinational. A parameter adds an output register, which is on by default.

Top module: `ro_fp32_rounder`

## Requirements
- R1: For a finite, untagged input with biased exponent (unbiased + 127) from 1 to 254, the output is {sign, biased exponent[7:0], the 23 mantissa bits just below the hidden bit}. When the discarded bits are all zero, the fraction is passed through unchanged and is never incremented.
- R2: When any guard bit or the sticky bit is nonzero, bit 0 of the packed output is 1. Bits 22:1 still equal the truncated fraction.
- R3: A finite, untagged input with biased exponent of 255 or more gives infinity: {sign, 8'hFF, 23'd0}.
- R4: A finite, untagged input with biased exponent of 0 or less gives {sign, 31'd0}.
- R5: A NaN tag gives 32'h7FC00000. This holds for any input sign, exponent or mantissa.
- R6: An infinity tag without a NaN tag gives {sign, 8'hFF, 23'd0}.
- R7: A zero tag without a NaN or infinity tag gives {sign, 31'd0}, whatever the exponent.
- R8: The tags take precedence in this order: NaN, then infinity, then zero, then the exponent range checks.
- R9: With OUT_REG=1, the output shows the result of inputs sampled at a rising clock edge, starting at that edge. Until then the output holds its previous value. A synchronous active-low reset clears it to 32'h00000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| in_sign | input | 1 | Sign of the unrounded result |
| in_exp | input | EXP_W | Unbiased exponent, two's complement |
| in_mant | input | 24+GUARD_W | Normalized mantissa: hidden one at the MSB, then 23 fraction bits, then guard bits |
| in_sticky | input | 1 | OR of all bits below the guard bits |
| in_nan | input | 1 | The result is a NaN |
| in_inf | input | 1 | The result is infinite |
| in_zero | input | 1 | The result is zero |
| result | output | 32 | Packed single-precision value |

## Verification
With the default output register, each result appears one clock edge after the inputs that produce it. The bench drives inputs on the falling edge and reads the output on the next falling edge, which is half a period after the capturing rising edge. One scenario also reads the output just after new inputs are driven, to confirm that it has not changed yet. The reset check holds non-trivial inputs while reset is asserted and reads the output only after a rising edge has passed.

// File: rtl/ro_pkg.sv
// Shared constants and the result-class type for the round-to-odd packer.
// Assumes the single-precision layout: 1 sign, 8 exponent and 23 fraction bits.
package ro_pkg;
    localparam int          FRAC_W  = 23;
    localparam int          EXPF_W  = 8;
    localparam int          BIAS    = 127;
    localparam int          EXP_MAX = 255;
    localparam logic [31:0] DEF_NAN = 32'h7FC0_0000;

    typedef enum logic [2:0] {
        K_NORM,
        K_OVF,
        K_FLUSH,
        K_NAN,
        K_INF,
        K_ZERO
    } kind_e;
endpackage

// File: rtl/ro_classify.sv
// Chooses the output class from the tags and the biased exponent.
// Assumes EXP_W >= 9, so that the bias fits in the signed sum.
module ro_classify
    import ro_pkg::*;
#(
    parameter int EXP_W = 10
) (
    input  logic [EXP_W-1:0]  in_exp,
    input  logic              in_nan,
    input  logic              in_inf,
    input  logic              in_zero,
    output kind_e             kind,
    output logic [EXPF_W-1:0] exp_field
);
    localparam int SW = EXP_W + 1;

    logic signed [SW-1:0] biased;

    // Sign-extend the exponent and add the bias.
    always_comb begin
        biased = $signed({in_exp[EXP_W-1], in_exp}) + $signed(SW'(BIAS));
    end

    // Apply the tag priority first, then the range checks.
    always_comb begin
        if (in_nan)
            kind = K_NAN;
        else if (in_inf)
            kind = K_INF;
        else if (in_zero)
            kind = K_ZERO;
        else if (biased >= $signed(SW'(EXP_MAX)))
            kind = K_OVF;
        else if (biased <= $signed(SW'(0)))
            kind = K_FLUSH;
        else
            kind = K_NORM;
    end

    assign exp_field = biased[EXPF_W-1:0];
endmodule

// File: rtl/ro_jam.sv
// Round-to-odd on the fraction: truncates the guard bits, then ORs the
// inexact indication into the fraction LSB. The fraction is never incremented.
// Assumes GUARD_W >= 1.
module ro_jam
    import ro_pkg::*;
#(
    parameter int GUARD_W = 3
) (
    input  logic [FRAC_W+GUARD_W-1:0] bits_in,
    input  logic                      sticky,
    output logic [FRAC_W-1:0]         frac,
    output logic                      inexact
);
    // Detect whether any discarded bit is nonzero.
    always_comb begin
        inexact = (|bits_in[GUARD_W-1:0]) | sticky;
    end

    // Keep the upper bits and force the LSB when the result is inexact.
    always_comb begin
        frac = bits_in[FRAC_W+GUARD_W-1:GUARD_W] | {{(FRAC_W-1){1'b0}}, inexact};
    end
endmodule

// File: rtl/ro_fp32_rounder.sv
// Packs an unrounded single-precision result with round-to-odd, overflow to
// signed infinity, flush-to-zero and default-NaN substitution.
// Assumes in_mant has its hidden one at the MSB whenever no tag is set.
// Keeps no exception flags. With OUT_REG=1 the result is registered.
module ro_fp32_rounder
    import ro_pkg::*;
#(
    parameter int EXP_W   = 10,
    parameter int GUARD_W = 3,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_sign,
    input  logic [EXP_W-1:0]        in_exp,
    input  logic [24+GUARD_W-1:0]   in_mant,
    input  logic                    in_sticky,
    input  logic                    in_nan,
    input  logic                    in_inf,
    input  logic                    in_zero,
    output logic [31:0]             result
);
    localparam int MANT_W = 24 + GUARD_W;

    kind_e             kind;
    logic [EXPF_W-1:0] exp_field;
    logic [FRAC_W-1:0] frac;
    logic              inexact;
    logic [31:0]       res_d;

    ro_classify #(.EXP_W(EXP_W)) u_class (
        .in_exp    (in_exp),
        .in_nan    (in_nan),
        .in_inf    (in_inf),
        .in_zero   (in_zero),
        .kind      (kind),
        .exp_field (exp_field)
    );

    ro_jam #(.GUARD_W(GUARD_W)) u_jam (
        .bits_in (in_mant[MANT_W-2:0]),
        .sticky  (in_sticky),
        .frac    (frac),
        .inexact (inexact)
    );

    // Build the packed word from the selected class.
    always_comb begin
        unique case (kind)
            K_NAN:          res_d = DEF_NAN;
            K_INF, K_OVF:   res_d = {in_sign, 8'hFF, 23'd0};
            K_ZERO, K_FLUSH: res_d = {in_sign, 31'd0};
            default:        res_d = {in_sign, exp_field, frac};
        endcase
    end

    generate
        if (OUT_REG) begin : g_reg
            logic [31:0] result_q;
            // Output register, cleared by the synchronous reset.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    result_q <= 32'd0;
                else
                    result_q <= res_d;
            end
            assign result = result_q;
        end else begin : g_comb
            assign result = res_d;
        end
    endgenerate

    // Checks on the combinational result, one per requirement.
    p_nan_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_nan |-> res_d == 32'h7FC0_0000);
    p_inf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_inf && !in_nan) |-> res_d == {in_sign, 8'hFF, 23'd0});
    p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_zero && !in_nan && !in_inf) |-> res_d == {in_sign, 31'd0});
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_OVF) |-> (res_d[30:0] == 31'h7F80_0000 && res_d[31] == in_sign));
    p_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_FLUSH) |-> (res_d[30:0] == 31'd0 && res_d[31] == in_sign));
    p_odd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_NORM && ((|in_mant[GUARD_W-1:0]) || in_sticky)) |-> res_d[0]);
    p_trunc_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_NORM) |-> res_d[22:1] == in_mant[MANT_W-2:GUARD_W+1]);
    p_hidden_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_NORM) |-> in_mant[MANT_W-1]);
endmodule

// File: tb/tb_ro_fp32_rounder.sv
// Directed bench for the round-to-odd packer with its output register on.
module tb_ro_fp32_rounder;
    localparam int EXP_W   = 10;
    localparam int GUARD_W = 3;
    localparam int MANT_W  = 24 + GUARD_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_sign = 1'b0;
    logic [EXP_W-1:0]  in_exp = '0;
    logic [MANT_W-1:0] in_mant = '0;
    logic              in_sticky = 1'b0;
    logic              in_nan = 1'b0;
    logic              in_inf = 1'b0;
    logic              in_zero = 1'b0;
    logic [31:0]       result;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    ro_fp32_rounder #(.EXP_W(EXP_W), .GUARD_W(GUARD_W), .OUT_REG(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .in_sign(in_sign), .in_exp(in_exp),
        .in_mant(in_mant), .in_sticky(in_sticky), .in_nan(in_nan),
        .in_inf(in_inf), .in_zero(in_zero), .result(result)
    );

    // Expected word worked out from the requirements.
    function automatic logic [31:0] model(input logic s, input int e,
            input logic [22:0] f, input logic [GUARD_W-1:0] g, input logic st,
            input logic n, input logic i, input logic z);
        int b;
        b = e + 127;
        if (n) return 32'h7FC0_0000;
        if (i) return {s, 8'hFF, 23'd0};
        if (z) return {s, 31'd0};
        if (b >= 255) return {s, 8'hFF, 23'd0};
        if (b <= 0) return {s, 31'd0};
        return {s, 8'(b), f | {22'd0, (|g) | st}};
    endfunction

    task automatic check(input string req, input logic [31:0] exp_v);
        n_vec++;
        if (result !== exp_v) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", req, result, exp_v);
        end
    endtask

    // Drive one operand on a falling edge and check it on the next falling edge.
    task automatic apply(input string req, input logic s, input int e,
            input logic [22:0] f, input logic [GUARD_W-1:0] g, input logic st,
            input logic n, input logic i, input logic z);
        @(negedge clk);
        in_sign = s; in_exp = EXP_W'(e); in_mant = {1'b1, f, g};
        in_sticky = st; in_nan = n; in_inf = i; in_zero = z;
        @(negedge clk);
        check(req, model(s, e, f, g, st, n, i, z));
    endtask

    task automatic t_reset;
        in_sign = 1'b1; in_exp = 10'd5; in_mant = '1; in_sticky = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 reset", 32'h0000_0000);
        rst_n = 1'b1;
    endtask

    task automatic t_exact;
        apply("R1 exact", 1'b0, 0, 23'h40_0000, 3'b000, 1'b0, 0, 0, 0);
        check("R1 literal", 32'h3FC0_0000);
        apply("R1 odd kept", 1'b1, -3, 23'h12_3457, 3'b000, 1'b0, 0, 0, 0);
    endtask

    task automatic t_odd;
        apply("R2 guard msb", 1'b1, 5, 23'h7F_FFFE, 3'b100, 1'b0, 0, 0, 0);
        check("R2 literal", 32'hC27F_FFFF);
        apply("R2 sticky only", 1'b0, 10, 23'h00_0000, 3'b000, 1'b1, 0, 0, 0);
        apply("R2 guard lsb", 1'b0, -20, 23'h55_5554, 3'b001, 1'b0, 0, 0, 0);
        apply("R2 all ones no carry", 1'b0, 1, 23'h7F_FFFF, 3'b111, 1'b1, 0, 0, 0);
    endtask

    task automatic t_range;
        apply("R3 biased 255", 1'b0, 128, 23'h00_0001, 3'b000, 1'b0, 0, 0, 0);
        apply("R3 signed max", 1'b1, 511, 23'h7F_FFFF, 3'b111, 1'b1, 0, 0, 0);
        apply("R1 biased 254", 1'b0, 127, 23'h7F_FFFF, 3'b000, 1'b0, 0, 0, 0);
        apply("R4 biased 0", 1'b1, -127, 23'h7F_FFFF, 3'b111, 1'b1, 0, 0, 0);
        apply("R4 min exp", 1'b0, -512, 23'h00_0000, 3'b010, 1'b0, 0, 0, 0);
        apply("R1 biased 1", 1'b0, -126, 23'h00_0000, 3'b000, 1'b0, 0, 0, 0);
    endtask

    task automatic t_tags;
        apply("R5 nan", 1'b1, 7, 23'h12_3456, 3'b101, 1'b1, 1, 0, 0);
        apply("R8 nan over inf+zero", 1'b1, 200, 23'h7F_FFFF, 3'b000, 1'b0, 1, 1, 1);
        apply("R6 inf", 1'b1, -300, 23'h00_0000, 3'b000, 1'b0, 0, 1, 0);
        apply("R8 inf over zero", 1'b0, 0, 23'h00_0000, 3'b000, 1'b0, 0, 1, 1);
        apply("R7 zero big exp", 1'b1, 300, 23'h3F_0000, 3'b111, 1'b1, 0, 0, 1);
    endtask

    // Output must not change before the capturing edge.
    task automatic t_latency;
        apply("R9 prime", 1'b0, 2, 23'h00_1000, 3'b000, 1'b0, 0, 0, 0);
        @(negedge clk);
        in_sign = 1'b1; in_nan = 1'b1;
        #2;
        check("R9 holds before edge", model(1'b0, 2, 23'h00_1000, 3'b000, 1'b0, 0, 0, 0));
        @(negedge clk);
        check("R9 after edge", 32'h7FC0_0000);
        in_nan = 1'b0;
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_exact();
        t_odd();
        t_range();
        t_tags();
        t_latency();
        finish_run();
    end
endmodule